// File: doc/BRIEF.md
# Paged MDIO 32-bit Register Bridge

This block lets a host reach the 32-bit internal registers of a switch whose register space sits behind a page register and is visible only through 16-bit Clause 22 MDIO registers. The host presents a byte address, a write flag and 32-bit write data. The bridge then issues three MDIO commands to an external MDIO master, one at a time. The first command is a page-select write. The other two carry the two 16-bit halves of the register. When the last command is acknowledged, the bridge returns the assembled read data with a one-clock done pulse.

The bridge first turns the byte address into a word address. It clears the two low bits and shifts the result right by one, so the word address is always even. The page value is taken from word-address bits 16..8. The upper half of the register uses the word address plus one. Each half is sent to PHY address `0x10 | word[7:5]` with register number `word[4:0]`.

The two access types use opposite half orders. A read fetches the low half first, which keeps clear-on-read counters consistent. A write stores the low half last, because that half may hold a busy or trigger bit. Framing on the MDC/MDIO pins belongs to the master and is not part of this block.

Top module: `mdio_page_bridge`

## Requirements
- R1: Each accepted access first issues an MDIO write to PHY 0x18, register 0. Its data is byte-address bits 17..9 (word-address bits 16..8), zero-extended to 16 bits. This page write is repeated on every access, with no caching of the previous page.
- R2: Both half commands use PHY address 0x10 OR byte-address bits 8..6. The low half uses register number {byte-address bits 5..2, 0}. The high half uses {byte-address bits 5..2, 1}.
- R3: A read issues the low-half read first and the high-half read second. Both have cmd_write = 0.
- R4: A write issues the high half first, carrying write data bits 31..16. It then issues the low half, carrying bits 15..0. Both have cmd_write = 1.
- R5: Read data is the high-half acknowledge data in bits 31..16 and the low-half acknowledge data in bits 15..0. It is valid from the done pulse onward.
- R6: Exactly three commands are issued per access. Each command is held stable with cmd_valid high until cmd_ack, and the next command appears only after that acknowledge.
- R7: A request is taken only while req_ready is high, which is only when the bridge is idle. A request presented while busy is ignored and changes no command of the access in progress.
- R8: done is high for exactly one clock, the one following the final acknowledge.
- R9: Byte-address bits 1..0 have no effect on any command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Bridge idle, request may be taken |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Assembled read data |
| cmd_valid | output | 1 | MDIO command pending |
| cmd_write | output | 1 | MDIO command is a write |
| cmd_phy | output | 5 | MDIO PHY address |
| cmd_reg | output | 5 | MDIO register number |
| cmd_wdata | output | 16 | MDIO write data |
| cmd_ack | input | 1 | Master acknowledge for the pending command |
| ack_rdata | input | 16 | Read data returned with the acknowledge |

## Verification
Random byte addresses across the full 18-bit range separate the page, PHY and register fields from each other. Mixing reads and writes with random data shows whether the half order flips with the direction and whether each data half lands on the right command. Random acknowledge delays, including zero wait, show whether commands stay held and strictly one at a time. Directed cases cover address zero, the top address, unaligned addresses compared against their aligned twins, and requests raised while the bridge is busy.

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge #(
  parameter int          ADDR_W   = 18,
  parameter logic [4:0]  PAGE_PHY = 5'h18,
  parameter logic [4:0]  BASE_PHY = 5'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [31:0]       rdata,
  output logic              cmd_valid,
  output logic              cmd_write,
  output logic [4:0]        cmd_phy,
  output logic [4:0]        cmd_reg,
  output logic [15:0]       cmd_wdata,
  input  logic              cmd_ack,
  input  logic [15:0]       ack_rdata
);
  localparam int WA_W = ADDR_W - 1;

  typedef enum logic [1:0] {S_IDLE, S_PAGE, S_FIRST, S_SECOND} st_t;

  st_t                state;
  logic [ADDR_W-1:2]  addr_q;
  logic               write_q;
  logic [31:0]        wdata_q;
  logic [15:0]        lo_q;

  logic [WA_W-1:0]    wa;
  logic [7:0]         half_wa;
  logic               page_sel;
  logic               hi_sel;
  logic               unused_lsb;

  assign unused_lsb = ^req_addr[1:0];

  assign wa       = {addr_q, 1'b0};
  assign page_sel = (state == S_PAGE);
  assign hi_sel   = ((state == S_FIRST) == write_q);
  assign half_wa  = hi_sel ? (wa[7:0] + 8'd1) : wa[7:0];

  assign req_ready = (state == S_IDLE);
  assign cmd_valid = (state != S_IDLE);
  assign cmd_write = page_sel | write_q;
  assign cmd_phy   = page_sel ? PAGE_PHY : (BASE_PHY | {2'b00, half_wa[7:5]});
  assign cmd_reg   = page_sel ? 5'd0 : half_wa[4:0];

  always_comb begin
    if (page_sel)      cmd_wdata = 16'(wa[WA_W-1:8]);
    else if (!write_q) cmd_wdata = 16'd0;
    else if (hi_sel)   cmd_wdata = wdata_q[31:16];
    else               cmd_wdata = wdata_q[15:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
      lo_q    <= '0;
      rdata   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr[ADDR_W-1:2];
          write_q <= req_write;
          wdata_q <= req_wdata;
          state   <= S_PAGE;
        end
        S_PAGE: if (cmd_ack) state <= S_FIRST;
        S_FIRST: if (cmd_ack) begin
          if (!write_q) lo_q <= ack_rdata;
          state <= S_SECOND;
        end
        S_SECOND: if (cmd_ack) begin
          if (!write_q) rdata <= {ack_rdata, lo_q};
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_page_bridge_chk.sv
module mdio_page_bridge_chk #(
  parameter logic [4:0] PAGE_PHY = 5'h18
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        done,
  input logic        cmd_valid,
  input logic        cmd_write,
  input logic [4:0]  cmd_phy,
  input logic [4:0]  cmd_reg,
  input logic [15:0] cmd_wdata,
  input logic        cmd_ack
);
  AST_ACCEPT_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> cmd_valid && cmd_write && cmd_phy == PAGE_PHY && cmd_reg == 5'd0); // R1

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ack |=> cmd_valid && $stable({cmd_write, cmd_phy, cmd_reg, cmd_wdata})); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cmd_valid && cmd_ack)); // R8
endmodule

bind mdio_page_bridge mdio_page_bridge_chk #(.PAGE_PHY(PAGE_PHY)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_phy(cmd_phy),
  .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata), .cmd_ack(cmd_ack)
);

// File: tb/mdio_page_bridge_tb_top.sv
module mdio_page_bridge_tb_top;
  localparam int ADDR_W = 18;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              req_ready, done, cmd_valid, cmd_write;
  logic [31:0]       rdata;
  logic [4:0]        cmd_phy, cmd_reg;
  logic [15:0]       cmd_wdata;
  logic              cmd_ack = 1'b0;
  logic [15:0]       ack_rdata = '0;

  int ntest = 0;
  int nfail = 0;
  int n_log = 0;
  int dly = 0;
  logic [26:0] log_q [8];

  always #5 clk = ~clk;

  mdio_page_bridge #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .rdata(rdata), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
    .cmd_ack(cmd_ack), .ack_rdata(ack_rdata)
  );

  function automatic logic [15:0] slave_val(logic [4:0] p, logic [4:0] r);
    return {p, r, 6'h15} ^ 16'hA5C3;
  endfunction

  function automatic logic [26:0] ent(logic w, logic [4:0] p, logic [4:0] r, logic [15:0] d);
    return {w, p, r, d};
  endfunction

  function automatic logic [4:0] exp_phy(logic [ADDR_W-1:0] a);
    return 5'h10 | {2'b00, a[8:6]};
  endfunction

  function automatic logic [4:0] exp_reg(logic [ADDR_W-1:0] a, logic hi);
    return {a[5:2], hi};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    ntest++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cmd_ack = 1'b0;
      if (cmd_valid) begin
        if (dly == 0) begin
          if (n_log < 8) log_q[n_log] = ent(cmd_write, cmd_phy, cmd_reg, cmd_wdata);
          n_log++;
          cmd_ack = 1'b1;
          ack_rdata = cmd_write ? 16'h0 : slave_val(cmd_phy, cmd_reg);
          dly = int'($urandom % 4);
        end else dly--;
      end
    end
  end

  task automatic access(logic [ADDR_W-1:0] a, logic w, logic [31:0] d, bit spurious);
    int cyc;
    logic [4:0] ph;
    @(negedge clk);
    chk("R7 ready when idle", 32'(req_ready), 32'd1);
    n_log = 0;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (spurious) begin
      req_valid = 1'b1; req_write = ~w; req_addr = ~a; req_wdata = ~d;
      chk("R7 ready low while busy", 32'(req_ready), 32'd0);
      @(negedge clk);
      req_valid = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
    chk("R8 done seen", 32'(done), 32'd1);
    chk("R6 three commands", 32'(n_log), 32'd3);
    ph = exp_phy(a);
    chk("R1 page write", 32'(log_q[0]), 32'(ent(1'b1, 5'h18, 5'd0, {7'd0, a[17:9]})));
    if (w) begin
      chk("R4 R2 high half first", 32'(log_q[1]), 32'(ent(1'b1, ph, exp_reg(a, 1'b1), d[31:16])));
      chk("R4 R2 low half last", 32'(log_q[2]), 32'(ent(1'b1, ph, exp_reg(a, 1'b0), d[15:0])));
    end else begin
      chk("R3 R2 low half first", 32'(log_q[1]), 32'(ent(1'b0, ph, exp_reg(a, 1'b0), 16'd0)));
      chk("R3 R2 high half second", 32'(log_q[2]), 32'(ent(1'b0, ph, exp_reg(a, 1'b1), 16'd0)));
      chk("R5 read data", rdata,
          {slave_val(ph, exp_reg(a, 1'b1)), slave_val(ph, exp_reg(a, 1'b0))});
    end
    @(negedge clk);
    chk("R8 done one clock", 32'(done), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R7 reset ready", 32'(req_ready), 32'd1);
    chk("R6 reset no command", 32'(cmd_valid), 32'd0);
    chk("R8 reset done low", 32'(done), 32'd0);
    rst_n = 1'b1;

    access(18'h00000, 1'b0, 32'h0, 1'b0);
    access(18'h3FFFC, 1'b1, 32'hDEAD_BEEF, 1'b0);
    access(18'h3FFFC, 1'b0, 32'h0, 1'b1);
    access(18'h1237C, 1'b0, 32'h0, 1'b0);
    access(18'h1237F, 1'b0, 32'h0, 1'b0);   // R9 unaligned twin
    access(18'h0ABC1, 1'b1, 32'h1234_5678, 1'b1); // R9
    access(18'h0ABC0, 1'b1, 32'h1234_5678, 1'b0);
    for (int i = 0; i < 60; i++)
      access(ADDR_W'($urandom), 1'($urandom), $urandom, 1'($urandom));

    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    ntest++;
    $display("FAIL watchdog expired R6 act=hung exp=finished");
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule